// File: doc/BRIEF.md
# Three-Bus Add Step Sequencer

This block is the hardwired control unit for one instruction of a three-bus processor datapath. The instruction is a register-to-register add. The unit walks through four named states and produces, in each one, the enables that the datapath needs:

- which register drives bus A;
- which registers drive bus B (the program counter, the memory data register or a general register);
- whether the ALU passes bus B straight through or adds A and B;
- the load strobes for the memory address register, the instruction register and the destination register;
- a memory read request;
- a program-counter increment;
- an end-of-instruction flag.

The states are `ST_FETCH`, `ST_WAIT_MEM`, `ST_LOAD_IR` and `ST_EXECUTE`. Their transitions are:

- `ST_FETCH` goes to `ST_WAIT_MEM` unconditionally.
- `ST_WAIT_MEM` stays where it is while the memory-complete input is low. It goes to `ST_LOAD_IR` once that input is high.
- `ST_LOAD_IR` goes to `ST_EXECUTE` unconditionally.
- `ST_EXECUTE` raises the end flag and goes back to `ST_FETCH`.

The fetch path needs no separate PC register path. The program counter goes onto bus B, and the ALU copies it to the address register in the same step that bumps the counter. The whole add then takes a single step, with both sources on their buses at once. The instruction register contents are fed back into the block. Three index fields are decoded into one-hot register enables. A monitor counts the drivers on each bus and flags any step with more than one.

Top module: `add_step_sequencer`

## Requirements
- R1: While the synchronous reset is high, every control output is low. The first cycle after reset is released shows the `ST_FETCH` outputs. A reset applied mid-instruction also returns the unit to `ST_FETCH`.
- R2: In `ST_FETCH`, exactly these outputs are high: `pc_drive_b`, `alu_pass_b`, `mar_load`, `mem_read` and `pc_inc`.
- R3: In `ST_WAIT_MEM`, every control output is low. The state holds for as many cycles as `mem_done` stays low.
- R4: `mem_done` high in `ST_WAIT_MEM` moves the unit to `ST_LOAD_IR` at the next clock. `mem_done` in any other state has no effect on the step order.
- R5: In `ST_LOAD_IR`, exactly these outputs are high: `mdr_drive_b`, `alu_pass_b` and `ir_load`.
- R6: In `ST_EXECUTE`, these outputs are high: `alu_add`, `sel_a` and `seq_end`. In addition:
  - `reg_drive_a` is one-hot at the index in `ir_word[5:3]`;
  - `reg_drive_b` is one-hot at the index in `ir_word[8:6]`;
  - `reg_load` is one-hot at the index in `ir_word[2:0]`;
  - all other outputs are low.
- R7: The cycle after `seq_end` is high shows the `ST_FETCH` outputs.
- R8: No step has more than one driver on bus A or on bus B, and `bus_conflict` stays low. This includes instructions whose source and destination fields are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_done | input | 1 | Memory signals that the requested read is complete |
| ir_word | input | 9 | Instruction register contents: dst [2:0], src A [5:3], src B [8:6] |
| pc_drive_b | output | 1 | Program counter drives bus B |
| mdr_drive_b | output | 1 | Memory data register drives bus B |
| reg_drive_a | output | 8 | One-hot general register drive onto bus A |
| reg_drive_b | output | 8 | One-hot general register drive onto bus B |
| alu_pass_b | output | 1 | ALU result equals bus B |
| alu_add | output | 1 | ALU adds its A and B operands |
| sel_a | output | 1 | ALU A operand taken from bus A |
| mar_load | output | 1 | Memory address register load |
| ir_load | output | 1 | Instruction register load |
| reg_load | output | 8 | One-hot destination register load |
| mem_read | output | 1 | Memory read request |
| pc_inc | output | 1 | Program counter increment |
| seq_end | output | 1 | Last step of the instruction |
| bus_conflict | output | 1 | More than one driver on bus A or bus B |

## Verification
The wait state is the hardest case to reach from the ports. It is the only state whose outputs are all low, so a stall that lasts too long or ends too early is visible only through the cycle in which the `ST_LOAD_IR` outputs appear. The stimulus sweeps all 512 field combinations and varies the stall length from zero to three cycles. On some instructions it holds `mem_done` high through the fetch, load and execute steps, so that an early or stray advance shows up as a mismatch. A reset asserted in the middle of a stall checks that the unit restarts cleanly.

// File: rtl/add_seq_pkg.sv
package add_seq_pkg;

    typedef enum logic [1:0] {
        ST_FETCH    = 2'd0,
        ST_WAIT_MEM = 2'd1,
        ST_LOAD_IR  = 2'd2,
        ST_EXECUTE  = 2'd3
    } seq_step_e;

endpackage

// File: rtl/seq_step_fsm.sv
module seq_step_fsm
    import add_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mem_done,
    output seq_step_e step
);

    seq_step_e step_q;
    seq_step_e step_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_FETCH;
        end else begin
            step_q <= step_d;
        end
    end

    // Transitions
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_FETCH:    step_d = ST_WAIT_MEM;
            ST_WAIT_MEM: step_d = mem_done ? ST_LOAD_IR : ST_WAIT_MEM;
            ST_LOAD_IR:  step_d = ST_EXECUTE;
            ST_EXECUTE:  step_d = ST_FETCH;
        endcase
    end

    assign step = step_q;

endmodule

// File: rtl/idx_onehot_decoder.sv
module idx_onehot_decoder #(
    parameter int NUM_OUT = 8,
    localparam int IDX_W  = $clog2(NUM_OUT)
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic               en,
    output logic [NUM_OUT-1:0] onehot
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
        assign onehot[i] = en && (idx == IDX_W'(i));
    end

endmodule

// File: rtl/bus_claim_monitor.sv
module bus_claim_monitor #(
    parameter int WIDTH_A = 8,
    parameter int WIDTH_B = 10
) (
    input  logic [WIDTH_A-1:0] drv_a,
    input  logic [WIDTH_B-1:0] drv_b,
    output logic               conflict
);

    localparam int CNT_W = $clog2(WIDTH_B + WIDTH_A + 1) + 1;

    logic [CNT_W-1:0] cnt_a;
    logic [CNT_W-1:0] cnt_b;

    always_comb begin
        cnt_a = '0;
        cnt_b = '0;
        for (int i = 0; i < WIDTH_A; i++) begin
            cnt_a = cnt_a + CNT_W'(drv_a[i]);
        end
        for (int j = 0; j < WIDTH_B; j++) begin
            cnt_b = cnt_b + CNT_W'(drv_b[j]);
        end
        conflict = (cnt_a > CNT_W'(1)) || (cnt_b > CNT_W'(1));
    end

endmodule

// File: rtl/add_step_sequencer.sv
module add_step_sequencer
    import add_seq_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int IR_W    = 3 * IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mem_done,
    input  logic [IR_W-1:0]     ir_word,
    output logic                pc_drive_b,
    output logic                mdr_drive_b,
    output logic [NUM_REGS-1:0] reg_drive_a,
    output logic [NUM_REGS-1:0] reg_drive_b,
    output logic                alu_pass_b,
    output logic                alu_add,
    output logic                sel_a,
    output logic                mar_load,
    output logic                ir_load,
    output logic [NUM_REGS-1:0] reg_load,
    output logic                mem_read,
    output logic                pc_inc,
    output logic                seq_end,
    output logic                bus_conflict
);

    localparam int DST_LSB  = 0;
    localparam int SRCA_LSB = IDX_W;
    localparam int SRCB_LSB = 2 * IDX_W;

    seq_step_e step;
    logic      exec_en;

    seq_step_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .mem_done (mem_done),
        .step     (step)
    );

    // Output decode
    always_comb begin
        pc_drive_b  = 1'b0;
        mdr_drive_b = 1'b0;
        alu_pass_b  = 1'b0;
        alu_add     = 1'b0;
        sel_a       = 1'b0;
        mar_load    = 1'b0;
        ir_load     = 1'b0;
        mem_read    = 1'b0;
        pc_inc      = 1'b0;
        seq_end     = 1'b0;
        exec_en     = 1'b0;
        if (!rst) begin
            unique case (step)
                ST_FETCH: begin
                    pc_drive_b = 1'b1;
                    alu_pass_b = 1'b1;
                    mar_load   = 1'b1;
                    mem_read   = 1'b1;
                    pc_inc     = 1'b1;
                end
                ST_WAIT_MEM: begin
                end
                ST_LOAD_IR: begin
                    mdr_drive_b = 1'b1;
                    alu_pass_b  = 1'b1;
                    ir_load     = 1'b1;
                end
                ST_EXECUTE: begin
                    sel_a   = 1'b1;
                    alu_add = 1'b1;
                    seq_end = 1'b1;
                    exec_en = 1'b1;
                end
            endcase
        end
    end

    idx_onehot_decoder #(.NUM_OUT(NUM_REGS)) u_dec_src_a (
        .idx    (ir_word[SRCA_LSB +: IDX_W]),
        .en     (exec_en),
        .onehot (reg_drive_a)
    );

    idx_onehot_decoder #(.NUM_OUT(NUM_REGS)) u_dec_src_b (
        .idx    (ir_word[SRCB_LSB +: IDX_W]),
        .en     (exec_en),
        .onehot (reg_drive_b)
    );

    idx_onehot_decoder #(.NUM_OUT(NUM_REGS)) u_dec_dst (
        .idx    (ir_word[DST_LSB +: IDX_W]),
        .en     (exec_en),
        .onehot (reg_load)
    );

    bus_claim_monitor #(
        .WIDTH_A (NUM_REGS),
        .WIDTH_B (NUM_REGS + 2)
    ) u_bus_mon (
        .drv_a    (reg_drive_a),
        .drv_b    ({reg_drive_b, pc_drive_b, mdr_drive_b}),
        .conflict (bus_conflict)
    );

endmodule

// File: rtl/add_step_sequencer_chk.sv
module add_step_sequencer_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                mem_done,
    input logic                pc_drive_b,
    input logic                mdr_drive_b,
    input logic [NUM_REGS-1:0] reg_drive_a,
    input logic [NUM_REGS-1:0] reg_drive_b,
    input logic                alu_pass_b,
    input logic                alu_add,
    input logic                sel_a,
    input logic                mar_load,
    input logic                ir_load,
    input logic [NUM_REGS-1:0] reg_load,
    input logic                mem_read,
    input logic                pc_inc,
    input logic                seq_end,
    input logic                bus_conflict
);

    logic quiet;
    assign quiet = !(pc_drive_b || mdr_drive_b || alu_pass_b || alu_add || sel_a ||
                     mar_load || ir_load || mem_read || pc_inc || seq_end ||
                     (|reg_drive_a) || (|reg_drive_b) || (|reg_load));

    always @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R1: assert (quiet)
                else $error("controls active during reset");
        end
    end

    assert_fetch_then_wait_R3: assert property (@(posedge clk) disable iff (rst)
        mem_read |=> quiet);

    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (quiet && !mem_done) |=> quiet);

    assert_done_advances_R4: assert property (@(posedge clk) disable iff (rst)
        (quiet && mem_done) |=> (ir_load && mdr_drive_b));

    assert_ir_then_exec_R5: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> seq_end);

    assert_exec_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        seq_end |-> ($countones(reg_load) == 1 && $countones(reg_drive_a) == 1 &&
                     $countones(reg_drive_b) == 1));

    assert_end_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        seq_end |=> (mar_load && pc_drive_b && pc_inc));

    assert_single_driver_R8: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(reg_drive_a) && $onehot0({reg_drive_b, pc_drive_b, mdr_drive_b})
         && !bus_conflict));

endmodule

bind add_step_sequencer add_step_sequencer_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mem_done     (mem_done),
    .pc_drive_b   (pc_drive_b),
    .mdr_drive_b  (mdr_drive_b),
    .reg_drive_a  (reg_drive_a),
    .reg_drive_b  (reg_drive_b),
    .alu_pass_b   (alu_pass_b),
    .alu_add      (alu_add),
    .sel_a        (sel_a),
    .mar_load     (mar_load),
    .ir_load      (ir_load),
    .reg_load     (reg_load),
    .mem_read     (mem_read),
    .pc_inc       (pc_inc),
    .seq_end      (seq_end),
    .bus_conflict (bus_conflict)
);

// File: tb/add_step_sequencer_tb_top.sv
module add_step_sequencer_tb_top;

    localparam int NR = 8;
    localparam int VW = 11 + 3 * NR;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_done = 1'b0;
    logic [8:0]    ir_word = '0;
    logic          pc_drive_b, mdr_drive_b, alu_pass_b, alu_add, sel_a;
    logic          mar_load, ir_load, mem_read, pc_inc, seq_end, bus_conflict;
    logic [NR-1:0] reg_drive_a, reg_drive_b, reg_load;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    add_step_sequencer #(.NUM_REGS(NR)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .mem_done     (mem_done),
        .ir_word      (ir_word),
        .pc_drive_b   (pc_drive_b),
        .mdr_drive_b  (mdr_drive_b),
        .reg_drive_a  (reg_drive_a),
        .reg_drive_b  (reg_drive_b),
        .alu_pass_b   (alu_pass_b),
        .alu_add      (alu_add),
        .sel_a        (sel_a),
        .mar_load     (mar_load),
        .ir_load      (ir_load),
        .reg_load     (reg_load),
        .mem_read     (mem_read),
        .pc_inc       (pc_inc),
        .seq_end      (seq_end),
        .bus_conflict (bus_conflict)
    );

    logic [VW-1:0] act;
    assign act = {pc_drive_b, mdr_drive_b, alu_pass_b, alu_add, sel_a, mar_load,
                  ir_load, mem_read, pc_inc, seq_end, bus_conflict,
                  reg_drive_a, reg_drive_b, reg_load};

    // step: 0 quiet, 1 fetch, 3 load IR, 4 execute
    function automatic logic [VW-1:0] expect_vec(int step, logic [8:0] ir);
        logic [10:0]   c;
        logic [NR-1:0] a, b, d;
        a = '0;
        b = '0;
        d = '0;
        c = '0;
        case (step)
            1: c = 11'b1_0_1_0_0_1_0_1_1_0_0;
            3: c = 11'b0_1_1_0_0_0_1_0_0_0_0;
            4: begin
                c = 11'b0_0_0_1_1_0_0_0_0_1_0;
                a = NR'(1) << ir[5:3];
                b = NR'(1) << ir[8:6];
                d = NR'(1) << ir[2:0];
            end
            default: c = '0;
        endcase
        return {c, a, b, d};
    endfunction

    task automatic check(string req, logic [VW-1:0] exp);
        #1;
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One instruction from fetch to end; wait_n stall cycles before mem_done
    task automatic run_instr(logic [8:0] ir, int wait_n, bit stray_done);
        mem_done = stray_done;
        check("R2 fetch", expect_vec(1, ir));
        tick();
        for (int w = 0; w < wait_n; w++) begin
            mem_done = 1'b0;
            check("R3 wait", expect_vec(0, ir));
            tick();
        end
        mem_done = 1'b1;
        check("R3 wait with done", expect_vec(0, ir));
        tick();
        mem_done = stray_done;
        ir_word  = ir;
        check("R4 R5 load IR", expect_vec(3, ir));
        tick();
        check("R6 execute", expect_vec(4, ir));
        tick();
        // next fetch is checked at the start of the following call (R7)
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) tick();
        mem_done = 1'b1;
        check("R1 reset quiet", expect_vec(0, '0));
        rst = 1'b0;
        check("R1 first fetch after reset", expect_vec(1, '0));

        for (int k = 0; k < 512; k++) begin
            run_instr(9'(k), k % 4, (k % 3) == 0);
        end
        check("R7 fetch after end", expect_vec(1, '0));
        tick();

        // Reset in the middle of a stall
        mem_done = 1'b0;
        check("R3 stall before reset", expect_vec(0, '0));
        rst = 1'b1;
        check("R1 reset mid instruction", expect_vec(0, '0));
        tick();
        rst = 1'b0;
        check("R1 restart at fetch", expect_vec(1, '0));

        // Same register everywhere: no conflict (R8)
        run_instr(9'b101_101_101, 2, 1'b0);
        check("R8 R7 fetch after same-index add", expect_vec(1, '0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule